// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits between the serial command frontend and the nonvolatile array of a small serial memory. When the frontend decodes a write instruction it hands over the start address. Each complete data byte that follows is placed into a page buffer of `PAGE_BYTES` entries. The buffer position comes from the low address bits, which advance with every byte and wrap inside the page. The upper address bits are held for the whole instruction. A valid mask records which buffer entries were actually loaded in this instruction.

When chip select rises, the frontend reports the end of the frame and whether any bits of an unfinished byte were pending. If at least one full byte arrived and no partial byte is pending, the block starts a self-timed program cycle of `CYCLE_CLKS` system clocks and raises `busy` for the whole cycle. At the start of that cycle it walks the page once in ascending offset order. Each loaded byte is offered to the array, but only if the protect unit approves the address on `mem_addr`. In the last busy cycle the block pulses a request that tells the status unit to clear its write enable latch.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy`, `wel_clear` and `mem_we` are low.
- R2: A write instruction whose `wr_start` arrives while `wel` is low is ignored entirely: no array write, no busy cycle, no `wel_clear`.
- R3: The first data byte goes to offset `wr_addr[4:0]` of the page selected by `wr_addr[ADDR_W-1:5]`. Each later byte uses the next offset modulo 32, and the upper address bits never change within the instruction.
- R4: When more than 32 bytes are sent, a byte that lands on an already loaded offset replaces the earlier value, and only the last value is programmed.
- R5: A program cycle starts only on `frame_end` with `partial_bits` low after at least one complete byte; `busy` rises in the cycle after that `frame_end`.
- R6: A `frame_end` with `partial_bits` high, or with no complete byte received, abandons the write: no busy cycle, no array write, no `wel_clear`.
- R7: `busy` stays high for exactly `CYCLE_CLKS` consecutive cycles.
- R8: `wel_clear` is high for exactly one cycle, the last cycle in which `busy` is high, and never outside a busy cycle.
- R9: `mem_we` is never high while `prot_ok` is low, so protected addresses keep their contents.
- R10: A program cycle writes each loaded offset exactly once, in ascending offset order, within its first 32 cycles. Offsets not loaded in the instruction are not written.
- R11: `wr_start`, `byte_valid` and `frame_end` arriving while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Pulse: write opcode and address received |
| wr_addr | input | ADDR_W | Start address of the write |
| wel | input | 1 | Current write enable latch state |
| byte_valid | input | 1 | Pulse: a complete data byte is on `byte_data` |
| byte_data | input | 8 | Received data byte |
| frame_end | input | 1 | Pulse: chip select has risen |
| partial_bits | input | 1 | Bits of an incomplete byte were pending at `frame_end` |
| prot_ok | input | 1 | Protect unit: `mem_addr` may be written |
| busy | output | 1 | Program cycle in progress |
| wel_clear | output | 1 | Request to clear the write enable latch |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array address, also the protect query |
| mem_wdata | output | 8 | Array write data |

## Verification
Array writes are combinational from the walk counter. The first one is due in the cycle after `frame_end`, and one slot follows per page offset. The scoreboard builds the expected write list in ascending offset order at the moment the frame ends. A monitor compares it against `mem_we` at each falling edge. `busy` is sampled at the falling edge right after the `frame_end` pulse and counted until it drops, which must take exactly `CYCLE_CLKS` samples. The `wel_clear` pulse must fall in the final sample. Abandoned and ignored writes are checked by watching `busy` and `wel_clear` over a full cycle length, and by reading back the bench's array model.

// File: rtl/page_write_pkg.sv
package page_write_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_LOAD = 2'd1,
    PW_PROG = 2'd2
  } pw_state_t;
endpackage

// File: rtl/page_buf.sv
module page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [OFS_W-1:0] ld_ofs,
  input  logic [7:0]       ld_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [7:0]       rd_data,
  output logic             rd_valid
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
    logic hit;
    assign hit = ld && (ld_ofs == OFS_W'(g));

    // valid bit: cleared per instruction, set on load
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_q[g] <= 1'b0;
      else if (clr) valid_q[g] <= 1'b0;
      else if (hit) valid_q[g] <= 1'b1;
    end

    // data byte: enable only, no reset needed
    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= ld_data;
    end
  end

  assign rd_data  = data_q[rd_ofs];
  assign rd_valid = valid_q[rd_ofs];
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CYCLE_CLKS = 48,
  parameter int CNT_W      = $clog2(CYCLE_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_CLKS - 1);

  logic [CNT_W-1:0] cnt_d, cnt_q;

  assign last = run && (cnt_q == LAST_CNT);

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = '0;
    else if (run && !last) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import page_write_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wel,
  input  logic              byte_valid,
  input  logic              frame_end,
  input  logic              partial_bits,
  input  logic              prog_done,
  output logic              busy,
  output logic              buf_clr,
  output logic              buf_ld,
  output logic [OFS_W-1:0]  ld_ofs,
  output logic [ADDR_W-OFS_W-1:0] page_base,
  output logic              prog_start
);
  pw_state_t state_d, state_q;
  logic [OFS_W-1:0]        ofs_d, ofs_q;
  logic [ADDR_W-OFS_W-1:0] base_d, base_q;
  logic                    got_d, got_q;

  assign buf_clr    = (state_q == PW_IDLE) && wr_start && wel;
  assign buf_ld     = (state_q == PW_LOAD) && byte_valid;
  assign prog_start = (state_q == PW_LOAD) && frame_end && !partial_bits
                      && (got_q || byte_valid);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PW_IDLE: if (buf_clr)   state_d = PW_LOAD;
      PW_LOAD: if (frame_end) state_d = prog_start ? PW_PROG : PW_IDLE;
      PW_PROG: if (prog_done) state_d = PW_IDLE;
      default:                state_d = PW_IDLE;
    endcase
  end

  always_comb begin
    ofs_d  = ofs_q;
    base_d = base_q;
    got_d  = got_q;
    if (buf_clr) begin
      ofs_d  = wr_addr[OFS_W-1:0];
      base_d = wr_addr[ADDR_W-1:OFS_W];
      got_d  = 1'b0;
    end else if (buf_ld) begin
      ofs_d  = ofs_q + 1'b1;
      got_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      ofs_q   <= '0;
      base_q  <= '0;
      got_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ofs_q   <= ofs_d;
      base_q  <= base_d;
      got_q   <= got_d;
    end
  end

  assign busy      = (state_q == PW_PROG);
  assign ld_ofs    = ofs_q;
  assign page_base = base_q;
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wel,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              frame_end,
  input  logic              partial_bits,
  input  logic              prot_ok,
  output logic              busy,
  output logic              wel_clear,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(CYCLE_CLKS);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

  logic                    buf_clr, buf_ld, prog_start, prog_last, walk;
  logic [OFS_W-1:0]        ld_ofs;
  logic [ADDR_W-OFS_W-1:0] page_base;
  logic [CNT_W-1:0]        cnt;
  logic [7:0]              rd_data;
  logic                    rd_valid;

  pw_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .wel(wel), .byte_valid(byte_valid), .frame_end(frame_end),
    .partial_bits(partial_bits), .prog_done(prog_last), .busy(busy),
    .buf_clr(buf_clr), .buf_ld(buf_ld), .ld_ofs(ld_ofs),
    .page_base(page_base), .prog_start(prog_start)
  );

  page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .ld(buf_ld), .ld_ofs(ld_ofs),
    .ld_data(byte_data), .rd_ofs(cnt[OFS_W-1:0]), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  prog_timer #(.CYCLE_CLKS(CYCLE_CLKS), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .run(busy),
    .cnt(cnt), .last(prog_last)
  );

  // the page walk occupies the first PAGE_BYTES cycles of the program cycle
  assign walk      = busy && (cnt < PAGE_CNT);
  assign mem_addr  = {page_base, cnt[OFS_W-1:0]};
  assign mem_wdata = rd_data;
  assign mem_we    = walk && rd_valid && prot_ok;
  assign wel_clear = prog_last;
endmodule

// File: rtl/page_write_chk.sv
module page_write_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_end,
  input logic partial_bits,
  input logic busy,
  input logic wel_clear,
  input logic mem_we,
  input logic prot_ok
);
  // R5
  busy_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_end) && !$past(partial_bits));

  // R8
  clr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |-> busy);

  // R8
  clr_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |=> !busy && !wel_clear);

  // R9
  protect_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> prot_ok);

  // R10
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R6
  partial_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && partial_bits && !busy) |=> !busy);
endmodule

bind page_write_seq page_write_chk i_page_write_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
  .partial_bits(partial_bits), .busy(busy), .wel_clear(wel_clear),
  .mem_we(mem_we), .prot_ok(prot_ok)
);

// File: tb/test_page_write_seq.sv
module test_page_write_seq;
  localparam int ADDR_W = 11;
  localparam int PAGE   = 32;
  localparam int CYCLE  = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 1'b0, wel = 1'b0, byte_valid = 1'b0;
  logic frame_end = 1'b0, partial_bits = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] byte_data = '0;
  logic prot_on = 1'b0;
  logic [ADDR_W-1:0] prot_lo = '0;
  logic prot_ok, busy, wel_clear, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] mem [2**ADDR_W];
  int q_addr[$];
  int q_data[$];

  // bench model of the write
  bit       m_active;
  int       m_base, m_ofs;
  bit       m_got;
  bit       m_v [PAGE];
  logic [7:0] m_d [PAGE];

  always #5 clk = ~clk;

  assign prot_ok = !(prot_on && (mem_addr >= prot_lo));

  page_write_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .CYCLE_CLKS(CYCLE))
    i_page_write_seq (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .wel(wel), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_end(frame_end), .partial_bits(partial_bits), .prot_ok(prot_ok),
    .busy(busy), .wel_clear(wel_clear), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic bit is_prot(int a);
    return prot_on && (a >= int'(prot_lo));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare every array write with the scoreboard (R3 R4 R9 R10)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (q_addr.size() == 0) begin
        check(0, "R10 unexpected write", int'(mem_addr), -1);
      end else begin
        int ea, ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        check(int'(mem_addr) == ea && int'(mem_wdata) == ed,
              "R3/R10 write", {mem_addr, mem_wdata}, {ea[ADDR_W-1:0], ed[7:0]});
      end
    end
  end

  task automatic start_write(int a);
    @(negedge clk);
    wr_start = 1'b1; wr_addr = a[ADDR_W-1:0];
    m_active = wel; m_base = a & ~(PAGE-1); m_ofs = a % PAGE; m_got = 0;
    for (int i = 0; i < PAGE; i++) m_v[i] = 0;
    @(negedge clk);
    wr_start = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = d;
    if (m_active) begin
      m_d[m_ofs] = d; m_v[m_ofs] = 1; m_ofs = (m_ofs + 1) % PAGE; m_got = 1;
    end
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic end_frame(bit partial, string req);
    bit commit;
    int n, clr_at, clr_cnt;
    commit = m_active && m_got && !partial;
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (m_v[i] && !is_prot(m_base + i)) begin
          q_addr.push_back(m_base + i);
          q_data.push_back(int'(m_d[i]));
        end
    @(negedge clk);
    frame_end = 1'b1; partial_bits = partial;
    @(negedge clk);
    frame_end = 1'b0; partial_bits = 1'b0;
    m_active = 0;
    n = 0; clr_at = -1; clr_cnt = 0;
    if (commit) begin
      while (busy && n < 4*CYCLE) begin
        if (wel_clear) begin clr_at = n; clr_cnt++; end
        n++;
        @(negedge clk);
      end
      check(n == CYCLE, {req, " R7 busy length"}, n, CYCLE);
      check(clr_at == CYCLE-1 && clr_cnt == 1, {req, " R8 wel_clear slot"},
            clr_at, CYCLE-1);
      check(q_addr.size() == 0, {req, " R10 writes pending"}, q_addr.size(), 0);
      wel = 1'b0;  // status unit reacts to wel_clear
    end else begin
      for (int i = 0; i < CYCLE + 4; i++) begin
        if (busy || wel_clear) n++;
        @(negedge clk);
      end
      check(n == 0, {req, " no cycle"}, n, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 2**ADDR_W; i++) mem[i] = 8'hA5;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !wel_clear && !mem_we, "R1 reset", {busy, wel_clear, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !wel_clear && !mem_we, "R1 after release", {busy, wel_clear, mem_we}, 0);

    // R2: latch clear -> whole instruction ignored
    wel = 1'b0;
    start_write(11'h1E4);
    send_byte(8'h11); send_byte(8'h22);
    end_frame(0, "R2");
    check(mem[11'h1E4] == 8'hA5, "R2 array unchanged", mem[11'h1E4], 8'hA5);

    // R3 R5: simple three-byte write
    wel = 1'b1;
    start_write(11'h1E4);
    send_byte(8'h31); send_byte(8'h32); send_byte(8'h33);
    end_frame(0, "R5");
    check(mem[11'h1E5] == 8'h32, "R3 middle byte", mem[11'h1E5], 8'h32);
    check(mem[11'h1E7] == 8'hA5, "R10 unloaded offset", mem[11'h1E7], 8'hA5);

    // R3: wrap inside the page, upper bits fixed
    wel = 1'b1;
    start_write(11'h25E);
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h43); send_byte(8'h44);
    end_frame(0, "R3 wrap");
    check(mem[11'h240] == 8'h43, "R3 wrapped to page start", mem[11'h240], 8'h43);
    check(mem[11'h260] == 8'hA5, "R3 next page untouched", mem[11'h260], 8'hA5);

    // R4: 34 bytes overwrite offsets 0 and 1
    wel = 1'b1;
    start_write(11'h300);
    for (int i = 0; i < 34; i++) send_byte(8'(i + 8'h50));
    end_frame(0, "R4");
    check(mem[11'h300] == 8'h70, "R4 overwrite offset0", mem[11'h300], 8'h70);
    check(mem[11'h302] == 8'h52, "R4 offset2 kept", mem[11'h302], 8'h52);

    // R6: chip select inside a byte
    wel = 1'b1;
    start_write(11'h400);
    send_byte(8'h61); send_byte(8'h62);
    end_frame(1, "R6 partial");
    check(mem[11'h400] == 8'hA5, "R6 partial no write", mem[11'h400], 8'hA5);

    // R6: no complete byte
    start_write(11'h408);
    end_frame(0, "R6 empty");

    // R9: protected upper half of a page
    wel = 1'b1; prot_on = 1'b1; prot_lo = 11'h6F0;
    start_write(11'h6E8);
    for (int i = 0; i < 16; i++) send_byte(8'(i + 8'h80));
    end_frame(0, "R9");
    check(mem[11'h6EF] == 8'h87, "R9 open byte written", mem[11'h6EF], 8'h87);
    check(mem[11'h6F0] == 8'hA5, "R9 protected kept", mem[11'h6F0], 8'hA5);
    prot_on = 1'b0;

    // R11: traffic during busy is ignored
    wel = 1'b1;
    start_write(11'h500);
    send_byte(8'h91);
    q_addr.push_back(11'h500); q_data.push_back(8'h91);
    m_active = 0;
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    begin
      int n;
      n = 1;
      @(negedge clk); wr_start = 1'b1; wr_addr = 11'h520;
      @(negedge clk); wr_start = 1'b0; byte_valid = 1'b1; byte_data = 8'hEE;
      @(negedge clk); byte_valid = 1'b0; frame_end = 1'b1;
      @(negedge clk); frame_end = 1'b0;
      n = 4;
      while (busy && n < 4*CYCLE) begin n++; @(negedge clk); end
      check(n == CYCLE, "R11 busy length unchanged", n, CYCLE);
      repeat (CYCLE + 4) @(negedge clk);
      check(!busy, "R11 no second cycle", busy, 0);
      check(mem[11'h520] == 8'hA5, "R11 no stray write", mem[11'h520], 8'hA5);
      check(q_addr.size() == 0, "R11 queued write done", q_addr.size(), 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule